// File: doc/BRIEF.md
# Sequential Byte-Program Controller for a Serial Flash

This block is the command side of a serial flash that accepts a multi-frame byte-program mode over a mode-0 SPI link. The first program frame gives an opcode, a 24-bit start address sent most significant byte first, and a data byte. Each later frame gives only the opcode and one data byte. The address advances by one for each later frame on its own, and no new write enable is needed between frames. Each accepted byte leaves the block as a one-cycle request to the memory array. After that request the block stays busy for a fixed number of clock cycles. The array reports a failed write on a flag that the block samples in the last busy cycle.

The block keeps a write-enable latch, a mode flag and an error flag. It checks the sector-protect input vector at two points: when a program sequence starts, and before each step to the next address. A protected sector, the top of the array, a malformed frame or a write-disable command ends the mode and clears the latch. The SPI pins are sampled with the system clock, which must run several times faster than the serial clock. The frame logic is a state machine with these states:

- IDLE: chip select is high.
- OPCODE: the first byte is being collected.
- ADDR: the start address is being collected.
- DATA: data bytes are being collected.
- STATUS: the status byte is being shifted out.
- SIMPLE: a one-byte command is waiting for the frame to end.
- IGNORE: the rest of the frame is dropped.

A falling chip select moves IDLE to OPCODE. A completed opcode byte moves OPCODE to STATUS, SIMPLE, ADDR, DATA or IGNORE. The last address byte moves ADDR to DATA. A rising chip select returns any state to IDLE.

Top module: `sqp_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, the mode is inactive, `so` is low and no array request is issued.
- R2: A frame holding exactly 8 bits of opcode 06h sets the write-enable latch. A frame holding exactly 8 bits of opcode 04h clears the latch and ends the program mode, so that a later opcode-plus-data frame is not programmed.
- R3: Opcode 05h shifts the status byte out on `so`, MSB first, with one bit changing after each falling `sck`. The byte is reloaded every 8 clocks. Bit 0 is busy, bit 1 is the write-enable latch, bit 5 is the error flag, and all other bits are 0. `so` is low outside a status read.
- R4: With the latch set and the mode inactive, a frame of ADh or AFh, three address bytes and one data byte causes one `arr_req` pulse after chip select rises. The pulse carries the address masked to its low 19 bits and the data byte.
- R5: While the mode is active, a frame of ADh or AFh followed by one data byte programs that byte at the previous address plus one, with no new write enable.
- R6: When a program frame carries several complete data bytes, only the last one is programmed.
- R7: A program frame is aborted if its bit count is not a multiple of 8, or if it holds fewer bytes than its kind needs (5 for the first frame, 2 for a later frame). An aborted frame programs nothing, clears the latch and ends the mode.
- R8: If the start address of a first frame lies in a protected sector, nothing is programmed and the latch is cleared. The sector index is address bits [18:16], and `sect_prot[i]` high protects sector i.
- R9: After the byte at address 07FFFFh is programmed, the mode ends and the latch is cleared. The address never wraps.
- R10: If the address after the byte just programmed lies in a protected sector, the mode ends after that byte and the latch is cleared. No request ever targets a protected sector.
- R11: Busy holds for PROG_CYCLES cycles after each request. While busy, every frame other than a status read is ignored, and the next address is not advanced.
- R12: `arr_fail` high in the last busy cycle sets the error flag. The flag clears when the next program request is issued.
- R13: A first program frame sent while the latch is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (status) |
| sect_prot | input | 8 | Per-sector protect flags |
| arr_req | output | 1 | One-cycle program request to the array |
| arr_addr | output | 19 | Byte address of the request |
| arr_data | output | 8 | Byte to program |
| arr_fail | input | 1 | Array failure flag, sampled in the last busy cycle |

## Verification
The checker watches four properties on every cycle:

- No request ever targets a protected sector.
- Every request needs the write-enable latch and is followed by busy.
- No request is issued while busy, and the mode flag never outlives the latch.
- `so` stays low outside a status read.

Only the bench's frame scenarios can show the rest. That covers address auto-increment, keeping only the last byte of a frame, the abort sweep over bit counts, and the exit at the array end and in front of a protected sector. It also covers the sampling of the error flag, which is visible only through status reads and the array request log.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_STATUS,
        ST_SIMPLE,
        ST_IGNORE
    } frame_st_e;

    localparam logic [7:0] OPC_SEQ_A = 8'hAD;
    localparam logic [7:0] OPC_SEQ_B = 8'hAF;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;

    localparam int STAT_BUSY = 0;
    localparam int STAT_WEL  = 1;
    localparam int STAT_ERR  = 5;

endpackage

// File: rtl/sqp_spi_rx.sv
module sqp_spi_rx #(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       sck_fall,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_done,
    output logic [2:0] bit_mod,
    output logic [2:0] byte_cnt,
    output logic [7:0] rx_byte
);

    logic [SYNC_N-1:0] sck_p, cs_p, si_p;
    logic              sck_d, cs_d;
    logic              sck_s, cs_s, si_s, sck_rise;

    assign sck_s = sck_p[SYNC_N-1];
    assign cs_s  = cs_p[SYNC_N-1];
    assign si_s  = si_p[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_p <= {sck_p[SYNC_N-2:0], sck};
            cs_p  <= {cs_p[SYNC_N-2:0], cs_n};
            si_p  <= {si_p[SYNC_N-2:0], si};
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d & ~cs_s;
    assign sck_fall = ~sck_s & sck_d & ~cs_s;
    assign cs_fall  = ~cs_s & cs_d;
    assign cs_rise  = cs_s & ~cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_mod   <= '0;
            byte_cnt  <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else if (cs_fall) begin
            bit_mod   <= '0;
            byte_cnt  <= '0;
            byte_done <= 1'b0;
        end else if (sck_rise) begin
            rx_byte   <= {rx_byte[6:0], si_s};
            bit_mod   <= bit_mod + 3'd1;
            byte_done <= (bit_mod == 3'd7);
            if (bit_mod == 3'd7 && byte_cnt != '1)
                byte_cnt <= byte_cnt + 3'd1;
        end else begin
            byte_done <= 1'b0;
        end
    end

endmodule

// File: rtl/sqp_busy_timer.sv
module sqp_busy_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(PROG_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/sqp_ctrl.sv
module sqp_ctrl
    import sqp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int ARR_AW      = 19,
    parameter int SECT_AW     = 16,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_N      = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sck,
    input  logic                              cs_n,
    input  logic                              si,
    output logic                              so,
    input  logic [(1<<(ARR_AW-SECT_AW))-1:0]  sect_prot,
    output logic                              arr_req,
    output logic [ARR_AW-1:0]                 arr_addr,
    output logic [7:0]                        arr_data,
    input  logic                              arr_fail
);

    localparam int         ADDR_BYTES = ADDR_W / 8;
    localparam logic [2:0] ADDR_END   = 3'(1 + ADDR_BYTES);
    localparam logic [2:0] NEED_FIRST = 3'(2 + ADDR_BYTES);
    localparam logic [2:0] NEED_NEXT  = 3'd2;

    frame_st_e          st_q, st_d;
    logic               sck_fall, cs_fall, cs_rise, byte_done;
    logic [2:0]         bit_mod, byte_cnt;
    logic [7:0]         rx_byte;
    logic               busy, done;
    logic               wel_q, seq_q, err_q;
    logic [ARR_AW-1:0]  sa_q, na_q, pa, pa_nx;
    logic [7:0]         opc_q, dat_q, sh_q, stat;
    logic               frame_ok, start_prot, nx_prot, at_last, rx_seq, in_stat;

    sqp_spi_rx #(.SYNC_N(SYNC_N)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .byte_done(byte_done), .bit_mod(bit_mod), .byte_cnt(byte_cnt),
        .rx_byte(rx_byte)
    );

    sqp_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(arr_req), .busy(busy), .done(done)
    );

    always_comb begin
        pa         = seq_q ? na_q : sa_q;
        pa_nx      = pa + 1'b1;
        at_last    = &pa;
        start_prot = sect_prot[sa_q[ARR_AW-1:SECT_AW]];
        nx_prot    = sect_prot[pa_nx[ARR_AW-1:SECT_AW]];
        frame_ok   = (bit_mod == 3'd0) && (byte_cnt >= (seq_q ? NEED_NEXT : NEED_FIRST));
        rx_seq     = (rx_byte == OPC_SEQ_A) || (rx_byte == OPC_SEQ_B);
        stat            = '0;
        stat[STAT_BUSY] = busy;
        stat[STAT_WEL]  = wel_q;
        stat[STAT_ERR]  = err_q;
    end

    assign in_stat = (st_q == ST_STATUS);
    assign so      = sh_q[7];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (cs_fall) st_d = ST_OPCODE;
            ST_OPCODE: if (byte_done) begin
                if (rx_byte == OPC_RDSR)                           st_d = ST_STATUS;
                else if (busy)                                     st_d = ST_IGNORE;
                else if (rx_seq)                                   st_d = seq_q ? ST_DATA : (wel_q ? ST_ADDR : ST_IGNORE);
                else if (rx_byte == OPC_WREN || rx_byte == OPC_WRDI) st_d = ST_SIMPLE;
                else                                               st_d = ST_IGNORE;
            end
            ST_ADDR:   if (byte_done && byte_cnt == ADDR_END) st_d = ST_DATA;
            ST_DATA, ST_STATUS, ST_SIMPLE, ST_IGNORE: st_d = st_q;
            default:   st_d = ST_IDLE;
        endcase
        if (cs_rise) st_d = ST_IDLE;
    end

    // outputs and frame-end actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q    <= 1'b0;
            seq_q    <= 1'b0;
            err_q    <= 1'b0;
            sa_q     <= '0;
            na_q     <= '0;
            opc_q    <= '0;
            dat_q    <= '0;
            sh_q     <= '0;
            arr_req  <= 1'b0;
            arr_addr <= '0;
            arr_data <= '0;
        end else begin
            arr_req <= 1'b0;
            if (done && arr_fail) err_q <= 1'b1;
            unique case (st_q)
                ST_OPCODE: if (byte_done) opc_q <= rx_byte;
                ST_ADDR: begin
                    if (byte_done) sa_q <= {sa_q[ARR_AW-9:0], rx_byte};
                    if (cs_rise)   wel_q <= 1'b0;
                end
                ST_DATA: begin
                    if (byte_done) dat_q <= rx_byte;
                    if (cs_rise) begin
                        if (!frame_ok) begin
                            wel_q <= 1'b0;
                            seq_q <= 1'b0;
                        end else if (!seq_q && start_prot) begin
                            wel_q <= 1'b0;
                        end else begin
                            arr_req  <= 1'b1;
                            arr_addr <= pa;
                            arr_data <= dat_q;
                            err_q    <= 1'b0;
                            if (at_last || nx_prot) begin
                                seq_q <= 1'b0;
                                wel_q <= 1'b0;
                            end else begin
                                seq_q <= 1'b1;
                                na_q  <= pa_nx;
                            end
                        end
                    end
                end
                ST_SIMPLE: if (cs_rise && bit_mod == 3'd0 && byte_cnt == 3'd1) begin
                    if (opc_q == OPC_WREN) begin
                        wel_q <= 1'b1;
                    end else begin
                        wel_q <= 1'b0;
                        seq_q <= 1'b0;
                    end
                end
                ST_STATUS: begin
                    if (cs_rise)       sh_q <= '0;
                    else if (sck_fall) sh_q <= (bit_mod == 3'd0) ? stat : {sh_q[6:0], 1'b0};
                end
                ST_IDLE, ST_IGNORE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sqp_ctrl_chk.sv
module sqp_ctrl_chk #(
    parameter int ARR_AW  = 19,
    parameter int SECT_AW = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              arr_req,
    input logic [ARR_AW-1:0]                 arr_addr,
    input logic [(1<<(ARR_AW-SECT_AW))-1:0]  sect_prot,
    input logic                              busy,
    input logic                              wel,
    input logic                              seq_on,
    input logic                              so,
    input logic                              st_status
);

    AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !sect_prot[arr_addr[ARR_AW-1:SECT_AW]]);                   // R10
    AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> $past(wel));                                                // R13
    AST_REQ_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> busy);                                                      // R11
    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arr_req);                                                     // R11
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req);                                                  // R4
    AST_MODE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        seq_on |-> wel);                                                        // R7
    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_status |-> !so);                                                    // R3

endmodule

bind sqp_ctrl sqp_ctrl_chk #(.ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .arr_req(arr_req), .arr_addr(arr_addr),
    .sect_prot(sect_prot), .busy(busy), .wel(wel_q), .seq_on(seq_q),
    .so(so), .st_status(in_stat)
);

// File: tb/sqp_ctrl_tb.sv
module sqp_ctrl_tb;

    localparam int HALF  = 6;
    localparam int PROG  = 300;
    localparam logic [7:0] SEQ_A = 8'hAD, SEQ_B = 8'hAF, WREN = 8'h06, WRDI = 8'h04, RDSR = 8'h05;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0, so;
    logic [7:0]  sect_prot = '0;
    logic        arr_req, arr_fail = 1'b0;
    logic [18:0] arr_addr;
    logic [7:0]  arr_data;

    int n_run = 0, n_fail = 0, req_n = 0;
    logic [18:0] last_a = '0;
    logic [7:0]  last_d = '0;
    logic [7:0]  st;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    sqp_ctrl #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
        .sect_prot(sect_prot), .arr_req(arr_req), .arr_addr(arr_addr),
        .arr_data(arr_data), .arr_fail(arr_fail)
    );

    // array model: log every request
    always @(negedge clk) if (rst_n && arr_req) begin
        req_n  <= req_n + 1;
        last_a <= arr_addr;
        last_d <= arr_data;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hp(); repeat (HALF) @(negedge clk); endtask

    task automatic spi_bits(input logic [63:0] v, input int n);
        cs_n = 1'b0; hp();
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i]; hp(); sck = 1'b1; hp(); sck = 1'b0;
        end
        hp(); cs_n = 1'b1; hp(); hp();
    endtask

    task automatic rdsr(output logic [7:0] s);
        cs_n = 1'b0; hp();
        for (int i = 7; i >= 0; i--) begin
            si = RDSR[i]; hp(); sck = 1'b1; hp(); sck = 1'b0;
        end
        s = '0;
        for (int i = 0; i < 8; i++) begin
            hp(); s = {s[6:0], so}; sck = 1'b1; hp(); sck = 1'b0;
        end
        hp(); cs_n = 1'b1; hp(); hp();
    endtask

    task automatic first(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
        spi_bits({24'h0, op, a, d}, 40);
    endtask

    task automatic nxt(input logic [7:0] op, input logic [7:0] d);
        spi_bits({48'h0, op, d}, 16);
    endtask

    task automatic wait_idle(); repeat (PROG + 20) @(negedge clk); endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 so low", so, 0);
        rdsr(st); chk("R1 status", st, 8'h00);
        chk("R1 no request", req_n, 0);

        // R13 first frame with latch clear
        first(SEQ_A, 24'h001000, 8'h11);
        chk("R13 ignored without latch", req_n, 0);

        // R2 write enable
        spi_bits(WREN, 8); rdsr(st); chk("R2 latch set", st, 8'h02);

        // R4 first frame, upper address bits dropped
        first(SEQ_A, 24'hF12340, 8'h5A);
        chk("R4 req count", req_n, 1);
        chk("R4 address", last_a, 19'h12340);
        chk("R4 data", last_d, 8'h5A);
        rdsr(st); chk("R3 busy in status", st, 8'h03);
        wait_idle();

        // R5 / R11: continuation, then frame while busy is ignored
        nxt(SEQ_B, 8'h11);
        chk("R5 addr+1", last_a, 19'h12341);
        nxt(SEQ_A, 8'h22);
        chk("R11 busy frame ignored", req_n, 2);
        wait_idle();
        nxt(SEQ_B, 8'h33);
        chk("R11 no skipped address", last_a, 19'h12342);
        chk("R11 data", last_d, 8'h33);
        wait_idle();

        // R5 sweep
        for (int k = 0; k < 6; k++) begin
            nxt((k % 2) ? SEQ_A : SEQ_B, 8'(8'h40 + 13 * k));
            chk("R5 sweep address", last_a, 19'(32'h12343 + k));
            chk("R5 sweep data", last_d, 32'(8'(8'h40 + 13 * k)));
            wait_idle();
        end

        // R6 several bytes, last kept
        spi_bits({32'h0, SEQ_B, 8'hC1, 8'hC2, 8'hC3}, 32);
        chk("R6 last byte", last_d, 8'hC3);
        chk("R6 address", last_a, 19'h12349);
        wait_idle();

        // R2 write disable ends the mode
        spi_bits(WRDI, 8); rdsr(st); chk("R2 latch cleared", st, 8'h00);
        base = req_n;
        nxt(SEQ_B, 8'h55);
        chk("R2 mode ended", req_n, base);

        // R7 abort sweep on later frames (8..15 bits)
        for (int n = 8; n < 16; n++) begin
            spi_bits(WREN, 8);
            first(SEQ_A, 24'h000200, 8'h01);
            wait_idle();
            base = req_n;
            spi_bits(64'(16'hAFA5 >> (16 - n)), n);
            chk("R7 abort no program", req_n, base);
            rdsr(st); chk("R7 abort clears latch", st, 8'h00);
            nxt(SEQ_B, 8'h02);
            chk("R7 mode ended", req_n, base);
        end
        // R7 truncated first frame
        spi_bits(WREN, 8);
        base = req_n;
        spi_bits({28'h0, SEQ_A, 24'h000300, 4'hF}, 36);
        chk("R7 short first frame", req_n, base);
        rdsr(st); chk("R7 short first latch", st, 8'h00);

        // R8 protected start
        sect_prot = 8'b0000_1000;
        spi_bits(WREN, 8);
        base = req_n;
        first(SEQ_B, 24'h030010, 8'h9C);
        chk("R8 protected start", req_n, base);
        rdsr(st); chk("R8 latch cleared", st, 8'h00);

        // R10 stop before protected sector
        sect_prot = 8'b0000_0100;
        spi_bits(WREN, 8);
        first(SEQ_A, 24'h01FFFE, 8'hE1);
        chk("R10 first addr", last_a, 19'h1FFFE);
        wait_idle(); rdsr(st); chk("R10 still active", st, 8'h02);
        nxt(SEQ_B, 8'hE2);
        chk("R10 last in sector", last_a, 19'h1FFFF);
        wait_idle(); rdsr(st); chk("R10 mode exit", st, 8'h00);
        base = req_n;
        nxt(SEQ_B, 8'hE3);
        chk("R10 no entry to protected", req_n, base);

        // R9 array end
        sect_prot = '0;
        spi_bits(WREN, 8);
        first(SEQ_A, 24'h07FFFE, 8'hF1);
        wait_idle();
        nxt(SEQ_A, 8'hF2);
        chk("R9 top address", last_a, 19'h7FFFF);
        wait_idle(); rdsr(st); chk("R9 mode exit", st, 8'h00);
        base = req_n;
        nxt(SEQ_A, 8'hF3);
        chk("R9 no wrap", req_n, base);

        // R12 error flag
        spi_bits(WREN, 8);
        arr_fail = 1'b1;
        first(SEQ_A, 24'h000400, 8'h66);
        wait_idle();
        arr_fail = 1'b0;
        rdsr(st); chk("R12 error set", st, 8'h22);
        nxt(SEQ_B, 8'h67);
        rdsr(st); chk("R12 error cleared on new program", st, 8'h03);
        wait_idle();
        rdsr(st); chk("R12 clean finish", st, 8'h02);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule